// File: doc/BRIEF.md
# Paged Address Translation Unit

This block widens a 16-bit processor memory address to a 24-bit physical address. The logical space is cut into sixteen 4 KB pages. The top four logical address bits pick one of sixteen 12-bit map entries, and the low twelve bits carry the byte offset inside the page. Each entry has two fields. A 4-bit region field selects one of sixteen 1 MB regions, and an 8-bit frame field selects a 4 KB frame inside that region. The physical address is the region, then the frame, then the offset. With this a 64 KB processor can reach 16 MB. Across the physical space, region 0 is I/O, region 1 is main SRAM, region 2 is flash, region 6 is the video controller and region 8 is bulk DRAM.

Software rewrites the map through a four-byte register window on a simple bus-slave port. One byte selects an entry, two bytes hold that entry's fields, and one byte is a read-only identification value. After reset the table holds a default layout, so the processor can boot without any setup. In that layout one SRAM frame shows through nine logical pages. The monitor sits at the top of the space with a shadow at page 0, and the last page opens the video memory. A boot-select input picks which of two monitor frames the default layout exposes.

Top module: `page_xlat_unit`

## Requirements
- R1: `pa_o` equals {entry[`la_i[15:12]`], `la_i[11:0]`} with no clock delay, so the low 12 address bits pass through unchanged.
- R2: In an entry, the 4-bit region field drives `pa_o[23:20]` and the 8-bit frame field drives `pa_o[19:12]`.
- R3: Default map, as {region, frame}. Pages 0 and 14 hold 0x10E when `boot_sel`=0 and 0x11E when it is 1. Pages 2 to 10 all hold 0x102. Pages 1, 11, 12 and 13 hold 0x101, 0x10B, 0x10C and 0x10D. Page 15 holds 0x600.
- R4: While `rst_n` is low, the table holds the default map for `boot_sel`=0. On the first rising clock edge after `rst_n` rises, the table is reloaded with the default map for the `boot_sel` level present at that edge.
- R5: Window offset 0 (`adr_i`=0) is the entry index. A write stores `dat_i[3:0]` and ignores `dat_i[7:4]`. A read returns the index in bits 3:0 with bits 7:4 at zero. The index is 0 after reset.
- R6: Offset 1 reads and writes the full frame field of the entry that the index selects.
- R7: Offset 2 reads and writes the region field of the selected entry in bits 3:0. On a write, `dat_i[7:4]` is ignored. On a read, bits 7:4 are zero.
- R8: Offset 3 reads the constant 0xA5. Writes to offset 3 change neither the index nor any entry.
- R9: `ack_o` rises on the clock edge after `cyc_i` and `stb_i` are both high, and stays high for exactly one cycle. Read data is valid on `dat_o` while `ack_o` is high.
- R10: A write to an entry takes effect on the edge that raises `ack_o`, so the new translation is visible on `pa_o` in the cycle that `ack_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 1 | Chooses which monitor frame the default map uses |
| la_i | input | 16 | Logical address from the processor |
| pa_o | output | 24 | Translated physical address |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| adr_i | input | 2 | Byte offset in the register window |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | One-cycle acknowledge |

## Verification
The bench builds the block with its default parameters: a 16-bit logical address, sixteen entries, 4-bit regions, 8-bit frames and an identification byte of 0xA5. At these sizes the bench can walk every entry after each reset, for both `boot_sel` levels. Random streams of index, field and identification accesses then hit every offset and every entry, including the ignored upper nibbles and the writes that must have no effect. Random logical addresses are translated against a model table between those accesses.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  // Region part of the boot-time map for a page
  function automatic int dflt_region(input int page, input bit boot);
    if (page == 15) return 6;
    return 1 + (boot ? 0 : 0);
  endfunction

  // Frame part of the boot-time map for a page
  function automatic int dflt_frame(input int page, input bit boot);
    if (page == 0 || page == 14) return boot ? 'h1E : 'h0E;
    if (page >= 2 && page <= 10) return 'h02;
    if (page == 15) return 'h00;
    return page;
  endfunction
endpackage

// File: rtl/pxu_map_table.sv
module pxu_map_table #(
  parameter int IDX_W = 4,
  parameter int HI_W  = 4,
  parameter int LO_W  = 8,
  localparam int N_ENT = 1 << IDX_W,
  localparam int ENT_W = HI_W + LO_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_i,
  input  logic                            boot_i,
  input  logic                            wr_lo_i,
  input  logic                            wr_hi_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [LO_W-1:0]                 wr_dat_i,
  output logic [N_ENT-1:0][ENT_W-1:0]     tbl_o
);
  import pxu_pkg::*;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam logic [ENT_W-1:0] RST_VAL =
      {HI_W'(dflt_region(i, 1'b0)), LO_W'(dflt_frame(i, 1'b0))};
    logic [ENT_W-1:0] ent_q, ent_d;
    logic             hit, ent_en;

    assign hit    = (wr_idx_i == IDX_W'(i));
    assign ent_en = load_i | (hit & (wr_lo_i | wr_hi_i));

    always_comb begin
      ent_d = ent_q;
      if (load_i) begin
        ent_d = {HI_W'(dflt_region(i, boot_i)), LO_W'(dflt_frame(i, boot_i))};
      end else begin
        if (hit && wr_lo_i) ent_d[LO_W-1:0]     = wr_dat_i;
        if (hit && wr_hi_i) ent_d[ENT_W-1:LO_W] = wr_dat_i[HI_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RST_VAL;
      else if (ent_en) ent_q <= ent_d;
    end

    assign tbl_o[i] = ent_q;

    // R6
    tbl_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && hit && !load_i) |=> (ent_q[LO_W-1:0] == $past(wr_dat_i)));
    // R7
    tbl_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_i && hit && !load_i) |=> (ent_q[ENT_W-1:LO_W] == $past(wr_dat_i[HI_W-1:0])));
  end
endmodule

// File: rtl/pxu_reg_port.sv
module pxu_reg_port #(
  parameter int         IDX_W   = 4,
  parameter int         HI_W    = 4,
  parameter int         LO_W    = 8,
  parameter logic [7:0] VERSION = 8'hA5,
  localparam int ENT_W = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [1:0]       adr_i,
  input  logic [LO_W-1:0]  dat_i,
  input  logic [ENT_W-1:0] sel_ent_i,
  output logic [LO_W-1:0]  dat_o,
  output logic             ack_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_lo_o,
  output logic             wr_hi_o
);
  logic             req;
  logic             ack_q, ack_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic [LO_W-1:0]  rd_q, rd_d;
  logic             rd_en;

  assign req     = cyc_i & stb_i & ~ack_q;
  assign wr_lo_o = req & we_i & (adr_i == 2'd1);
  assign wr_hi_o = req & we_i & (adr_i == 2'd2);
  assign idx_en  = req & we_i & (adr_i == 2'd0);
  assign rd_en   = req & ~we_i;

  always_comb begin
    ack_d = req;
    idx_d = dat_i[IDX_W-1:0];
    unique case (adr_i)
      2'd0:    rd_d = LO_W'(idx_q);
      2'd1:    rd_d = sel_ent_i[LO_W-1:0];
      2'd2:    rd_d = LO_W'(sel_ent_i[ENT_W-1:LO_W]);
      default: rd_d = VERSION;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      idx_q <= '0;
      rd_q  <= '0;
    end else begin
      ack_q <= ack_d;
      if (idx_en) idx_q <= idx_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign ack_o = ack_q;
  assign idx_o = idx_q;
  assign dat_o = rd_q;

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  // R9
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && stb_i && !ack_o) |=> ack_o);
  // R8
  version_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && stb_i && !ack_o && !we_i && adr_i == 2'd3) |=> (dat_o == VERSION));
endmodule

// File: rtl/pxu_xlat.sv
module pxu_xlat #(
  parameter int LA_W  = 16,
  parameter int IDX_W = 4,
  parameter int HI_W  = 4,
  parameter int LO_W  = 8,
  localparam int N_ENT = 1 << IDX_W,
  localparam int ENT_W = HI_W + LO_W,
  localparam int OFF_W = LA_W - IDX_W,
  localparam int PA_W  = ENT_W + OFF_W
) (
  input  logic [LA_W-1:0]             la_i,
  input  logic [N_ENT-1:0][ENT_W-1:0] tbl_i,
  output logic [PA_W-1:0]             pa_o
);
  logic [IDX_W-1:0] page;
  assign page = la_i[LA_W-1:OFF_W];
  assign pa_o = {tbl_i[page], la_i[OFF_W-1:0]};
endmodule

// File: rtl/page_xlat_unit.sv
module page_xlat_unit #(
  parameter int         LA_W    = 16,
  parameter int         IDX_W   = 4,
  parameter int         HI_W    = 4,
  parameter int         LO_W    = 8,
  parameter logic [7:0] VERSION = 8'hA5,
  localparam int N_ENT = 1 << IDX_W,
  localparam int ENT_W = HI_W + LO_W,
  localparam int OFF_W = LA_W - IDX_W,
  localparam int PA_W  = ENT_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boot_sel,
  input  logic [LA_W-1:0] la_i,
  output logic [PA_W-1:0] pa_o,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [1:0]      adr_i,
  input  logic [LO_W-1:0] dat_i,
  output logic [LO_W-1:0] dat_o,
  output logic            ack_o
);
  logic                        load_q, load_d;
  logic [N_ENT-1:0][ENT_W-1:0] tbl;
  logic [IDX_W-1:0]            idx;
  logic                        wr_lo, wr_hi;

  assign load_d = 1'b0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= load_d;
  end

  pxu_reg_port #(.IDX_W(IDX_W), .HI_W(HI_W), .LO_W(LO_W), .VERSION(VERSION)) u_port (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .dat_i(dat_i), .sel_ent_i(tbl[idx]), .dat_o(dat_o),
    .ack_o(ack_o), .idx_o(idx), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi)
  );

  pxu_map_table #(.IDX_W(IDX_W), .HI_W(HI_W), .LO_W(LO_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .load_i(load_q), .boot_i(boot_sel),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_idx_i(idx), .wr_dat_i(dat_i),
    .tbl_o(tbl)
  );

  pxu_xlat #(.LA_W(LA_W), .IDX_W(IDX_W), .HI_W(HI_W), .LO_W(LO_W)) u_xlat (
    .la_i(la_i), .tbl_i(tbl), .pa_o(pa_o)
  );

  // R4
  load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);
endmodule

// File: tb/tb_page_xlat_unit.sv
module tb_page_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n, boot_sel, cyc_i, stb_i, we_i;
  logic [15:0] la_i;
  logic [23:0] pa_o;
  logic [1:0]  adr_i;
  logic [7:0]  dat_i, dat_o;
  logic        ack_o;

  int   n_tests = 0, n_fail = 0;
  bit   done = 0;
  logic [11:0] mtbl [16];
  logic [3:0]  midx;

  always #2.5 clk = ~clk;

  page_xlat_unit dut (.clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .la_i(la_i),
    .pa_o(pa_o), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i),
    .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o));

  function automatic logic [11:0] dflt(input int p, input bit b);
    if (p == 0 || p == 14) return b ? 12'h11E : 12'h10E;
    if (p >= 2 && p <= 10) return 12'h102;
    if (p == 15) return 12'h600;
    return {4'h1, 8'(p)};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {4'h0, midx};
      2'd1: return mtbl[midx][7:0];
      2'd2: return {4'h0, mtbl[midx][11:8]};
      default: return 8'hA5;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_xlat(input logic [15:0] la, input string req);
    la_i = la;
    #1;
    chk(pa_o == {mtbl[la[15:12]], la[11:0]}, req, pa_o, {mtbl[la[15:12]], la[11:0]});
  endtask

  // starts and ends at a negedge
  task automatic bus(input bit we, input logic [1:0] a, input logic [7:0] d, output logic [7:0] rd);
    bit ak1, ak2;
    cyc_i = 1; stb_i = 1; we_i = we; adr_i = a; dat_i = d;
    @(posedge clk); @(negedge clk);
    ak1 = ack_o; rd = dat_o;
    cyc_i = 0; stb_i = 0;
    if (we) begin
      case (a)
        2'd0: midx = d[3:0];
        2'd1: mtbl[midx][7:0] = d;
        2'd2: mtbl[midx][11:8] = d[3:0];
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    ak2 = ack_o;
    chk(ak1 && !ak2, "R9 ack pulse", {ak1, ak2}, 2'b10);
  endtask

  task automatic do_reset(input bit b);
    rst_n = 0; boot_sel = b; cyc_i = 0; stb_i = 0; we_i = 0; adr_i = 0; dat_i = 0;
    for (int p = 0; p < 16; p++) mtbl[p] = dflt(p, 1'b0);
    midx = 0;
    repeat (3) @(negedge clk);
    chk_xlat(16'h0123, "R4 map during reset");
    chk_xlat(16'hE456, "R4 map during reset");
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    for (int p = 0; p < 16; p++) mtbl[p] = dflt(p, b);
    chk(ack_o == 0 && dat_o == 0, "R9 reset outputs", {ack_o, dat_o}, 0);
    for (int p = 0; p < 16; p++) chk_xlat({4'(p), 12'hA5C}, "R3 R4 default map");
  endtask

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h1234));
    la_i = 0;
    do_reset(0);
    do_reset(1);
    chk_xlat(16'h0FFF, "R1 offset top");
    chk_xlat(16'hF000, "R2 video region");

    bus(0, 2'd0, 0, rd); chk(rd == 8'h00, "R5 index after reset", rd, 0);
    bus(0, 2'd3, 0, rd); chk(rd == 8'hA5, "R8 version", rd, 8'hA5);
    bus(1, 2'd0, 8'hF7, rd);
    bus(0, 2'd0, 0, rd); chk(rd == 8'h07, "R5 index upper ignored", rd, 8'h07);
    bus(0, 2'd1, 0, rd); chk(rd == 8'h02, "R6 frame read", rd, 8'h02);
    bus(1, 2'd3, 8'h5A, rd);
    bus(0, 2'd0, 0, rd); chk(rd == 8'h07, "R8 write no index effect", rd, 8'h07);
    bus(0, 2'd1, 0, rd); chk(rd == 8'h02, "R8 write no entry effect", rd, 8'h02);
    bus(0, 2'd3, 0, rd); chk(rd == 8'hA5, "R8 version after write", rd, 8'hA5);
    bus(1, 2'd1, 8'hC3, rd);
    bus(1, 2'd2, 8'hF8, rd);
    bus(0, 2'd2, 0, rd); chk(rd == 8'h08, "R7 region upper ignored", rd, 8'h08);
    chk_xlat(16'h7ABC, "R2 R10 rewritten entry");
    chk_xlat(16'h6ABC, "R1 alias untouched");

    // R10: translation in the ack cycle
    la_i = 16'h7001;
    cyc_i = 1; stb_i = 1; we_i = 1; adr_i = 2'd1; dat_i = 8'h44;
    @(posedge clk); @(negedge clk);
    mtbl[7][7:0] = 8'h44;
    chk(ack_o == 1 && pa_o == {mtbl[7], 12'h001}, "R10 write visible in ack cycle",
        pa_o, {mtbl[7], 12'h001});
    cyc_i = 0; stb_i = 0;
    @(posedge clk); @(negedge clk);

    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [7:0] d = 8'($urandom);
      logic [7:0] ex;
      if (op == 0) begin
        chk_xlat(16'($urandom), "R1 random translate");
      end else if (op == 1) begin
        ex = exp_rd(a);
        bus(0, a, 0, rd);
        chk(rd == ex, "R5 R6 R7 R8 random read", rd, ex);
      end else begin
        bus(1, a, d, rd);
      end
    end
    for (int p = 0; p < 16; p++) chk_xlat({4'(p), 12'h3C3}, "R2 final table");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule